// File: doc/BRIEF.md
# Vectored Interrupt Arbiter with Global Enable

This block chooses which interrupt request a processor core services next. It takes up to 23 request lines. Each line is already gated by the mask bit of its own peripheral. The block also holds the 8-bit status register, whose top bit is the global interrupt enable. Program memory starts with 24 fixed vector slots, each two words long. Slot 0 is reset and is never arbitrated. Request line `i` belongs to slot `i+1`, and the handler address of slot `k` is word address `2*k`.

Suppose the global enable is set and at least one request is pending. The block then latches the lowest-numbered pending slot and offers its vector address on a valid/ready interface. The offer is accepted in the cycle where valid and ready are both high. In that cycle the block drives a one-hot acknowledge back to the chosen source, so the peripheral can drop its flag. On the next edge the block clears the global enable, which keeps nested entry out until the handler finishes. A return-from-interrupt pulse sets the enable again. Software may rewrite the whole status register at any time. Saving and restoring the other status bits is left to the handler.

Back-pressure rules for the vector interface:
- Once valid rises, the vector address stays constant until the handshake, even if a request of higher priority arrives meanwhile.
- Valid may fall without a handshake in one case only: the global enable is about to drop through a software write.
- The acknowledge is a one-cycle pulse, driven only in the handshake cycle.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is asserted, the status register reads 0x00, `vec_valid` is 0 and `src_ack` is all zeros.
- R2: A status write (`sr_wr_en`=1) loads all 8 bits of `sr_wr_data` into `sr_value` at the next clock edge, unless R7 or R9 overrides bit 7.
- R3: While `sr_value[7]` is 0, `vec_valid` stays 0. Requests that arrive in that time stay pending and are offered once the enable is set.
- R4: If the enable is 1, no offer is held and some `irq_req` bit is 1 at a clock edge, `vec_valid` is 1 after that edge. `vec_addr` then equals 2·(i+1), where i is the chosen request bit.
- R5: When several request bits are set, the lowest bit index wins. Priority therefore follows the vector address.
- R6: While `vec_valid`=1 and `vec_ready`=0, the offer and `vec_addr` are held, even if requests change. `src_ack` is one-hot with bit i set only in the handshake cycle, and zero in every other cycle.
- R7: A handshake clears `sr_value[7]` and `vec_valid` at the next edge.
- R8: A `ret_pulse` sets `sr_value[7]` at the next edge. If no write happens in the same cycle, bits 6..0 keep their value.
- R9: When a handshake coincides with a write of bit 7 = 1 or with `ret_pulse`, the clear wins and `sr_value[7]` is 0 after the edge.
- R10: A software write that clears bit 7 while an offer is held drops `vec_valid` at the next edge, with no acknowledge.
- R11: Slot 0 is never offered. Request bit 22 yields `vec_addr` = 46.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 23 | Masked request lines; bit i belongs to slot i+1 |
| sr_wr_en | input | 1 | Software write strobe for the status register |
| sr_wr_data | input | 8 | Status register write value; bit 7 is the global enable |
| ret_pulse | input | 1 | Return-from-interrupt executed |
| vec_ready | input | 1 | Core accepts the offered vector |
| vec_valid | output | 1 | A vector is offered |
| vec_addr | output | 16 | Word address of the offered handler slot |
| src_ack | output | 23 | One-hot acknowledge to the serviced source |
| sr_value | output | 8 | Current status register |

## Verification
Three situations are hard to reach from the ports:
- a held offer that meets a higher-priority request and still has to keep its address;
- a handshake that lands in the same cycle as a status write of 1 or a return pulse;
- an offer withdrawn by a software write.

The stimulus builds the offer under a low `vec_ready` and then changes the requests. It lines up the handshake with a write or a return pulse on purpose. A long random phase then keeps ready, writes and returns varied, and a behavioural model checks every cycle.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int NUM_SLOTS  = 24;
  localparam int NUM_SRC    = NUM_SLOTS - 1;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int SLOT_WORDS = 2;
  localparam int ADDR_W     = 16;
  localparam int SR_W       = 8;
  localparam int GIE_BIT    = 7;

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [SLOT_W-1:0] slot);
    return ADDR_W'(slot) * ADDR_W'(SLOT_WORDS);
  endfunction
endpackage

// File: rtl/ivc_pick.sv
module ivc_pick
  import ivc_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int SW = SLOT_W
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [SW-1:0] slot
);
  logic [N-1:0] lower;
  logic [N-1:0] grant;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      if (g == 0) begin : g_first
        assign lower[g] = 1'b0;
      end else begin : g_rest
        assign lower[g] = lower[g-1] | req[g-1];
      end
      assign grant[g] = req[g] & ~lower[g];
    end
  endgenerate

  always_comb begin
    slot = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) slot = slot | SW'(i + 1);
    end
  end

  assign any = |req;
endmodule

// File: rtl/ivc_status.sv
module ivc_status
  import ivc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            ret,
  input  logic            we,
  input  logic [SR_W-1:0] wdata,
  output logic [SR_W-1:0] sr_q,
  output logic            gie_q,
  output logic            gie_nxt
);
  logic [SR_W-1:0] sr_nxt;

  always_comb begin
    sr_nxt = we ? wdata : sr_q;
    if (fire)     sr_nxt[GIE_BIT] = 1'b0;
    else if (ret) sr_nxt[GIE_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_nxt;
  end

  assign gie_q   = sr_q[GIE_BIT];
  assign gie_nxt = sr_nxt[GIE_BIT];

  AST_FIRE_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !sr_q[GIE_BIT]) else $error("enable survived accept"); // R7
  AST_RETI_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !fire) |=> sr_q[GIE_BIT]) else $error("return did not enable"); // R8
  AST_RETI_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !we) |=> (sr_q[GIE_BIT-1:0] == $past(sr_q[GIE_BIT-1:0]))) else $error("return touched low bits"); // R8
endmodule

// File: rtl/ivc_offer.sv
module ivc_offer
  import ivc_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int SW = SLOT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gie_q,
  input  logic          gie_nxt,
  input  logic          any,
  input  logic [SW-1:0] win_slot,
  input  logic          ready,
  output logic          valid,
  output logic [SW-1:0] slot,
  output logic          fire,
  output logic [N-1:0]  ack
);
  logic load;

  assign fire = valid & ready;
  assign load = ~valid & gie_q & gie_nxt & any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      slot  <= '0;
    end else if (!gie_nxt) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      slot  <= win_slot;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_ack
      assign ack[g] = fire && (slot == SW'(g + 1));
    end
  endgenerate

  AST_NO_VALID_WITHOUT_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> gie_q) else $error("offer while disabled"); // R3
  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && gie_nxt) |=> (valid && $stable(slot))) else $error("offer changed"); // R6
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack)) else $error("ack not one-hot"); // R6
  AST_SLOT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (slot != '0)) else $error("reset slot offered"); // R11
  AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !gie_nxt) |=> !valid) else $error("offer not withdrawn"); // R10
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               sr_wr_en,
  input  logic [SR_W-1:0]    sr_wr_data,
  input  logic               ret_pulse,
  input  logic               vec_ready,
  output logic               vec_valid,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic [NUM_SRC-1:0] src_ack,
  output logic [SR_W-1:0]    sr_value
);
  logic              any;
  logic [SLOT_W-1:0] win_slot;
  logic [SLOT_W-1:0] held_slot;
  logic              fire;
  logic              gie_q;
  logic              gie_nxt;

  ivc_pick #(.N(NUM_SRC), .SW(SLOT_W)) u_pick (
    .req  (irq_req),
    .any  (any),
    .slot (win_slot)
  );

  ivc_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .ret     (ret_pulse),
    .we      (sr_wr_en),
    .wdata   (sr_wr_data),
    .sr_q    (sr_value),
    .gie_q   (gie_q),
    .gie_nxt (gie_nxt)
  );

  ivc_offer #(.N(NUM_SRC), .SW(SLOT_W)) u_offer (
    .clk      (clk),
    .rst_n    (rst_n),
    .gie_q    (gie_q),
    .gie_nxt  (gie_nxt),
    .any      (any),
    .win_slot (win_slot),
    .ready    (vec_ready),
    .valid    (vec_valid),
    .slot     (held_slot),
    .fire     (fire),
    .ack      (src_ack)
  );

  assign vec_addr = slot_addr(held_slot);

  AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_addr[0] == 1'b0 && vec_addr != '0)) else $error("bad vector address"); // R4
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int NS    = 23;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq_req = '0;
  logic          sr_wr_en = 1'b0;
  logic [7:0]    sr_wr_data = '0;
  logic          ret_pulse = 1'b0;
  logic          vec_ready = 1'b0;
  logic          vec_valid;
  logic [15:0]   vec_addr;
  logic [NS-1:0] src_ack;
  logic [7:0]    sr_value;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  int m_sr = 0;
  bit m_vld = 1'b0;
  int m_slot = 0;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sr_wr_en(sr_wr_en),
    .sr_wr_data(sr_wr_data), .ret_pulse(ret_pulse), .vec_ready(vec_ready),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .src_ack(src_ack),
    .sr_value(sr_value)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  // behavioural reference: advanced once per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sr = 0; m_vld = 1'b0; m_slot = 0;
    end else begin
      bit took;
      int nsr;
      int first;
      took = m_vld && vec_ready;
      nsr = sr_wr_en ? int'(sr_wr_data) : m_sr;
      if (took)           nsr = nsr & 8'h7F;
      else if (ret_pulse) nsr = nsr | 8'h80;
      first = -1;
      for (int i = NS - 1; i >= 0; i--) if (irq_req[i]) first = i;
      if (nsr < 128) m_vld = 1'b0;
      else if (!m_vld && m_sr >= 128 && first >= 0) begin
        m_vld = 1'b1;
        m_slot = first + 1;
      end
      m_sr = nsr;
    end
  end

  always @(negedge clk) begin
    #4;
    if (cmp_on) begin
      chk("R3/R4 valid", 32'(vec_valid), 32'(m_vld));
      if (m_vld) chk("R5 vector", 32'(vec_addr), 32'(m_slot * 2));
      chk("R6 ack", 32'(src_ack), (m_vld && vec_ready) ? (32'd1 << (m_slot - 1)) : 32'd0);
      chk("R2/R8 sr", 32'(sr_value), 32'(m_sr));
    end
  end

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    repeat (3) tick();
    chk("R1 sr", 32'(sr_value), 32'h0);
    chk("R1 valid", 32'(vec_valid), 32'h0);
    chk("R1 ack", 32'(src_ack), 32'h0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    tick();

    // R3: pending while disabled
    irq_req = (NS'(1) << 3) | (NS'(1) << 10) | (NS'(1) << 22);
    repeat (4) tick();
    chk("R3 held off", 32'(vec_valid), 32'h0);
    sr_wr_en = 1'b1; sr_wr_data = 8'h80;
    tick();
    sr_wr_en = 1'b0;
    chk("R2 write", 32'(sr_value), 32'h80);
    tick();
    chk("R4 valid", 32'(vec_valid), 32'h1);
    chk("R5 lowest wins", 32'(vec_addr), 32'd8);

    // R6: hold under back-pressure while a higher priority arrives
    irq_req = NS'(1);
    repeat (3) tick();
    chk("R6 held valid", 32'(vec_valid), 32'h1);
    chk("R6 held addr", 32'(vec_addr), 32'd8);
    vec_ready = 1'b1;
    #1;
    chk("R6 ack bit", 32'(src_ack), 32'h8);
    tick();
    vec_ready = 1'b0;
    irq_req = '0;
    chk("R7 enable cleared", 32'(sr_value[7]), 32'h0);
    chk("R7 valid dropped", 32'(vec_valid), 32'h0);

    // R8: return sets only bit 7
    sr_wr_en = 1'b1; sr_wr_data = 8'h2A;
    tick();
    sr_wr_en = 1'b0; ret_pulse = 1'b1;
    tick();
    ret_pulse = 1'b0;
    chk("R8 return", 32'(sr_value), 32'hAA);

    // R11: top source
    irq_req = NS'(1) << 22;
    tick();
    chk("R11 valid", 32'(vec_valid), 32'h1);
    chk("R11 addr", 32'(vec_addr), 32'd46);

    // R9: accept with a write of 1
    vec_ready = 1'b1; sr_wr_en = 1'b1; sr_wr_data = 8'hFF;
    tick();
    vec_ready = 1'b0; sr_wr_en = 1'b0;
    chk("R9 write loses", 32'(sr_value), 32'h7F);

    // R9: accept with return
    ret_pulse = 1'b1;
    tick();
    ret_pulse = 1'b0;
    tick();
    chk("R9 reoffer", 32'(vec_valid), 32'h1);
    vec_ready = 1'b1; ret_pulse = 1'b1;
    tick();
    vec_ready = 1'b0; ret_pulse = 1'b0;
    chk("R9 return loses", 32'(sr_value[7]), 32'h0);

    // R10: software clear withdraws offer
    ret_pulse = 1'b1;
    tick();
    ret_pulse = 1'b0;
    tick();
    chk("R10 offered", 32'(vec_valid), 32'h1);
    sr_wr_en = 1'b1; sr_wr_data = 8'h00;
    #1;
    chk("R10 no ack", 32'(src_ack), 32'h0);
    tick();
    sr_wr_en = 1'b0;
    chk("R10 withdrawn", 32'(vec_valid), 32'h0);

    // random phase against the model
    for (int c = 0; c < 4000; c++) begin
      irq_req    = ($urandom % 4 == 0) ? NS'($urandom) & NS'($urandom) : '0;
      vec_ready  = ($urandom % 3 == 0);
      sr_wr_en   = ($urandom % 40 == 0);
      sr_wr_data = 8'($urandom);
      ret_pulse  = !sr_value[7] && ($urandom % 4 == 0);
      tick();
    end
    sr_wr_en = 1'b0; ret_pulse = 1'b0;
    tick();
    report();
  end
endmodule